// File: doc/BRIEF.md
# Level Run-Length Capture Encoder

This block watches one asynchronous digital input and turns it into a list of constant-level runs. While capture is enabled, it samples the synchronized input once per clock. Each time the level changes, it emits one packed word. The word holds the level of the run that just ended and the number of clock ticks that run lasted. A downstream memory stores the words, and a player that counts ticks per word can later rebuild the waveform from them. The block also reports how many words were delivered, so the replay memory can be sized to that depth.

Capture is controlled by the level input `cap_en`:

- A rise of `cap_en` while the block is idle starts a capture.
- A fall of `cap_en` stops it, and the run still in progress is emitted as the final word.

The controller has three states:

- **IDLE** waits for a start. Transition START goes to CAPT.
- **CAPT** samples the input. It stays in CAPT on a HOLD (same level) or on a SPLIT (level change). It leaves on STOP (`cap_en` low) or on FILL (the word that fills the segment budget was delivered), both going to DRAIN.
- **DRAIN** waits until the last word has been taken. Transition RELEASE goes back to IDLE.

A rise of `cap_en` is recognised only in IDLE.

Top module: `rle_capture`

## Requirements
- R1: Each output word carries the run level in bit TICKS_WIDTH and the run duration in bits TICKS_WIDTH-1..0. `seg_index` gives the word's position in the capture, starting at 0.
- R2: The input passes through a two-stage synchronizer, so the encoder sees a pin level two clocks after it was sampled. Durations are counted in clocks. The durations of one capture add up to the number of rising clock edges at which `cap_en` was sampled high, from the start edge up to (but not including) the stop edge.
- R3: A run ends at the first sample whose level differs from the current run. The next run begins at that same sample. No emitted duration is ever 0.
- R4: When `cap_en` is sampled low during capture, the run in progress is emitted as the final word.
- R5: If the level never changes during a capture, exactly one word is produced. It carries the starting level and the whole capture length.
- R6: A run longer than 2^TICKS_WIDTH-1 ticks is reported as 2^TICKS_WIDTH-1. `ovf_flag` is then set and stays set until the next start.
- R7: `seg_count` equals the number of words delivered in the current capture. `busy` is high from the start edge until the block returns to IDLE.
- R8: Output uses valid/ready handshaking, and a word is held unchanged while `seg_valid` is high and `seg_ready` is low. If a new run completes while a word is still pending, that run is lost. `drop_flag` is set and stays set until the next start, and `seg_count` is not incremented.
- R9: When `seg_count` reaches MAX_SEGMENTS, capture ends by itself and `full_flag` is set. `busy` falls once the last word is accepted. No further words appear while `cap_en` stays high.
- R10: A rise of `cap_en` in IDLE does three things. It clears `seg_count`, `ovf_flag`, `drop_flag` and `full_flag`. It latches the synchronized level as the first run's level. It counts that sample as the run's first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable; rise starts, fall stops |
| pin_in | input | 1 | Raw asynchronous input being recorded |
| seg_valid | output | 1 | Output word is valid |
| seg_ready | input | 1 | Downstream accepts the word this cycle |
| seg_word | output | TICKS_WIDTH+1 | {level, duration} |
| seg_index | output | clog2(MAX_SEGMENTS+1) | Ordinal of the word within the capture |
| seg_count | output | clog2(MAX_SEGMENTS+1) | Words delivered so far |
| busy | output | 1 | Capture or drain in progress |
| ovf_flag | output | 1 | Sticky: a duration saturated |
| drop_flag | output | 1 | Sticky: a run was lost to back-pressure |
| full_flag | output | 1 | Sticky: segment budget reached |

## Verification
The hardest situation to reach from the ports is saturation of the duration counter. At the default width it needs billions of clocks. The bench therefore instantiates the block with a 6-bit duration and holds one level for 70 clocks. It then checks the clamped value and that the sticky flag survives until the next start.

Losing a word also requires two runs to complete while the consumer is stalled. The bench holds `seg_ready` low across a level change and then a stop. The budget limit is reached by toggling the pin every two clocks with `cap_en` held high, which also shows that no restart happens without a fresh rise.

// File: rtl/rle_cap_pkg.sv
package rle_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAPT  = 2'd1,
        ST_DRAIN = 2'd2
    } cap_state_e;

endpackage

// File: rtl/rle_sync.sv
// Multi-stage synchronizer for the asynchronous input pin.
module rle_sync #(
    parameter int STAGES = 2
)(
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rle_run_counter.sv
// Saturating run-length tick counter: clear loads 1, step adds one.
module rle_run_counter #(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] tick,
    output logic         sat
);
    assign sat = &tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (clear) begin
            tick <= W'(1);
        end else if (step && !sat) begin
            tick <= tick + 1'b1;
        end
    end

    // R6: once at the ceiling, further steps keep it there
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && step && !clear) |=> sat);
endmodule

// File: rtl/rle_word_out.sv
// Output word register with valid/ready, ordinal, delivered count, drop flag.
module rle_word_out #(
    parameter int TW = 32,
    parameter int CW = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic          lvl,
    input  logic [TW-1:0] dur,
    input  logic          seg_ready,
    output logic          seg_valid,
    output logic [TW:0]   seg_word,
    output logic [CW-1:0] seg_index,
    output logic [CW-1:0] seg_count,
    output logic          drop_flag
);
    logic take;

    assign take = load && (!seg_valid || seg_ready);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_valid <= 1'b0;
            seg_word  <= '0;
            seg_index <= '0;
            seg_count <= '0;
            drop_flag <= 1'b0;
        end else begin
            if (clr) begin
                seg_count <= '0;
                drop_flag <= 1'b0;
            end
            if (take) begin
                seg_valid <= 1'b1;
                seg_word  <= {lvl, dur};
                seg_index <= seg_count;
                seg_count <= seg_count + 1'b1;
            end else if (seg_valid && seg_ready) begin
                seg_valid <= 1'b0;
            end
            if (load && !take) begin
                drop_flag <= 1'b1;
            end
        end
    end

    // R3: a presented duration is never zero
    p_min_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_word[TW-1:0] != '0));

    // R8: a stalled word stays put
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_word)));

    // R8: a lost run does not advance the count
    p_drop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seg_valid && !seg_ready && !clr) |=> ($stable(seg_count) && drop_flag));
endmodule

// File: rtl/rle_capture.sv
// Level run-length capture encoder: top level with control state machine.
module rle_capture
    import rle_cap_pkg::*;
#(
    parameter int TICKS_WIDTH  = 32,
    parameter int MAX_SEGMENTS = 1024,
    parameter int SYNC_STAGES  = 2
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_en,
    input  logic                              pin_in,
    output logic                              seg_valid,
    input  logic                              seg_ready,
    output logic [TICKS_WIDTH:0]              seg_word,
    output logic [$clog2(MAX_SEGMENTS+1)-1:0] seg_index,
    output logic [$clog2(MAX_SEGMENTS+1)-1:0] seg_count,
    output logic                              busy,
    output logic                              ovf_flag,
    output logic                              drop_flag,
    output logic                              full_flag
);
    localparam int CNT_W = $clog2(MAX_SEGMENTS + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(MAX_SEGMENTS - 1);

    cap_state_e state, nxt;
    logic lvl_s, en_q, cur_lvl;
    logic emit, restart, step, clr, set_full, slot_free;
    logic [TICKS_WIDTH-1:0] tick;
    logic tick_sat;
    logic ovf_q, full_q;

    rle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s)
    );

    rle_run_counter #(.W(TICKS_WIDTH)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(restart), .step(step),
        .tick(tick), .sat(tick_sat)
    );

    rle_word_out #(.TW(TICKS_WIDTH), .CW(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(emit), .lvl(cur_lvl),
        .dur(tick), .seg_ready(seg_ready), .seg_valid(seg_valid),
        .seg_word(seg_word), .seg_index(seg_index), .seg_count(seg_count),
        .drop_flag(drop_flag)
    );

    assign slot_free = !seg_valid || seg_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and control strobes
    always_comb begin
        nxt      = state;
        emit     = 1'b0;
        restart  = 1'b0;
        step     = 1'b0;
        clr      = 1'b0;
        set_full = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cap_en && !en_q) begin          // START
                    clr     = 1'b1;
                    restart = 1'b1;
                    nxt     = ST_CAPT;
                end
            end
            ST_CAPT: begin
                if (!cap_en) begin                  // STOP
                    emit = 1'b1;
                    nxt  = ST_DRAIN;
                end else if (lvl_s != cur_lvl) begin // SPLIT
                    emit    = 1'b1;
                    restart = 1'b1;
                end else begin                      // HOLD
                    step = 1'b1;
                end
                if (emit && slot_free && (seg_count == LAST_SLOT)) begin // FILL
                    set_full = 1'b1;
                    nxt      = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!seg_valid) begin               // RELEASE
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Datapath and sticky flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            cur_lvl <= 1'b0;
            ovf_q   <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            en_q <= cap_en;
            if (restart) begin
                cur_lvl <= lvl_s;
            end
            if (clr) begin
                ovf_q  <= 1'b0;
                full_q <= 1'b0;
            end else begin
                if (step && tick_sat) begin
                    ovf_q <= 1'b1;
                end
                if (set_full) begin
                    full_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        ovf_flag  = ovf_q;
        full_flag = full_q;
    end

    // R6: overflow flag only clears at a start
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(state == ST_IDLE && cap_en && !en_q)) |=> ovf_flag);

    // R10: a start leaves count and flags cleared
    p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cap_en && !en_q) |=>
        (seg_count == '0 && !ovf_flag && !drop_flag && !full_flag && busy));

    // R9: count never exceeds the budget
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_count <= CNT_W'(MAX_SEGMENTS));

    // R9: reaching the budget leaves capture
    p_full_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_flag) |-> (state == ST_DRAIN));
endmodule

// File: tb/test_rle_capture.sv
module test_rle_capture;
    localparam int TW = 6;
    localparam int MS = 8;
    localparam int CW = $clog2(MS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_en = 1'b0;
    logic pin_in = 1'b0;
    logic seg_ready = 1'b1;
    logic seg_valid, busy, ovf_flag, drop_flag, full_flag;
    logic [TW:0] seg_word;
    logic [CW-1:0] seg_index, seg_count;

    rle_capture #(.TICKS_WIDTH(TW), .MAX_SEGMENTS(MS)) i_rle_capture (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pin_in(pin_in),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_word(seg_word),
        .seg_index(seg_index), .seg_count(seg_count), .busy(busy),
        .ovf_flag(ovf_flag), .drop_flag(drop_flag), .full_flag(full_flag)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_err = 0;

    // Word monitor: a word seen valid&ready at the falling edge is taken at the next rise
    logic [TW:0]   mon_word [0:63];
    logic [CW-1:0] mon_idx  [0:63];
    int mon_n = 0;
    always @(negedge clk) begin
        if (rst_n && seg_valid && seg_ready && mon_n < 64) begin
            mon_word[mon_n] <= seg_word;
            mon_idx[mon_n]  <= seg_index;
            mon_n <= mon_n + 1;
        end
    end

    // Stimulus table: first level, run count, run lengths (levels alternate)
    localparam int NROW = 4;
    localparam int ROW_LVL [NROW] = '{1, 0, 1, 0};
    localparam int ROW_N   [NROW] = '{1, 3, 4, 3};
    localparam int ROW_LEN [NROW][4] = '{'{5, 0, 0, 0}, '{3, 4, 5, 0},
                                         '{1, 1, 1, 2}, '{10, 2, 7, 0}};

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic run_all();
        int base;
        // Reset state
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R7 reset valid", int'(seg_valid), 0);
        check("R7 reset count", int'(seg_count), 0);
        check("R7 reset busy", int'(busy), 0);
        check("R6 reset ovf", int'(ovf_flag), 0);
        check("R8 reset drop", int'(drop_flag), 0);
        check("R9 reset full", int'(full_flag), 0);

        // Table walk: first word gains 2 ticks of synchronizer lead (R2)
        for (int r = 0; r < NROW; r++) begin
            int b;
            int tot;
            int exp_tot;
            pin_in = ROW_LVL[r][0];
            repeat (4) tick();
            b = mon_n;
            cap_en = 1'b1;
            exp_tot = 2;
            for (int j = 0; j < ROW_N[r]; j++) begin
                pin_in = ROW_LVL[r][0] ^ j[0];
                repeat (ROW_LEN[r][j]) tick();
                exp_tot += ROW_LEN[r][j];
            end
            repeat (2) tick();
            cap_en = 1'b0;
            repeat (6) tick();
            check("R7 count after capture", int'(seg_count), ROW_N[r]);
            check(r == 0 ? "R5 single word" : "R3 word total", mon_n - b, ROW_N[r]);
            check("R7 busy after drain", int'(busy), 0);
            tot = 0;
            for (int j = 0; j < ROW_N[r]; j++) begin
                int el;
                el = ROW_LEN[r][j] + ((j == 0) ? 2 : 0);
                check("R1 level bit", int'(mon_word[b + j][TW]), ROW_LVL[r] ^ (j & 1));
                check(j == ROW_N[r] - 1 ? "R4 final duration" : "R3 duration",
                      int'(mon_word[b + j][TW-1:0]), el);
                check("R1 index", int'(mon_idx[b + j]), j);
                tot += int'(mon_word[b + j][TW-1:0]);
            end
            check("R2 duration sum", tot, exp_tot);
        end

        // Budget limit: toggle every 2 clocks with enable held high
        pin_in = 1'b0;
        repeat (4) tick();
        base = mon_n;
        cap_en = 1'b1;
        for (int k = 0; k < 30; k++) begin
            repeat (2) tick();
            pin_in = ~pin_in;
        end
        check("R9 words at budget", mon_n - base, MS);
        check("R9 full flag", int'(full_flag), 1);
        check("R9 busy low", int'(busy), 0);
        check("R9 count", int'(seg_count), MS);
        check("R9 first duration", int'(mon_word[base]), 4);
        check("R9 last word", int'(mon_word[base + MS - 1]), (1 << TW) + 2);
        cap_en = 1'b0;
        repeat (4) tick();
        check("R9 no restart", mon_n - base, MS);
        check("R9 full sticky", int'(full_flag), 1);

        // Back-pressure: second run completes while first word stalls
        seg_ready = 1'b0;
        pin_in = 1'b0;
        repeat (4) tick();
        base = mon_n;
        cap_en = 1'b1;
        tick();
        check("R10 full cleared", int'(full_flag), 0);
        repeat (2) tick();
        pin_in = 1'b1;
        repeat (5) tick();
        cap_en = 1'b0;
        repeat (3) tick();
        check("R8 held valid", int'(seg_valid), 1);
        check("R8 held word", int'(seg_word), 5);
        check("R8 drop flag", int'(drop_flag), 1);
        check("R8 count not bumped", int'(seg_count), 1);
        check("R7 busy while draining", int'(busy), 1);
        seg_ready = 1'b1;
        repeat (4) tick();
        check("R8 words delivered", mon_n - base, 1);
        check("R8 delivered word", int'(mon_word[base]), 5);
        check("R7 idle after drain", int'(busy), 0);

        // Saturation at 6-bit width
        pin_in = 1'b1;
        repeat (4) tick();
        base = mon_n;
        cap_en = 1'b1;
        tick();
        check("R10 drop cleared", int'(drop_flag), 0);
        check("R10 count cleared", int'(seg_count), 0);
        check("R10 busy", int'(busy), 1);
        repeat (69) tick();
        cap_en = 1'b0;
        repeat (5) tick();
        check("R6 saturated word", int'(mon_word[base]), (1 << TW) + (1 << TW) - 1);
        check("R6 ovf flag", int'(ovf_flag), 1);
        check("R6 one word", mon_n - base, 1);
        repeat (3) tick();
        check("R6 ovf sticky", int'(ovf_flag), 1);

        // Next start clears overflow
        pin_in = 1'b0;
        repeat (4) tick();
        cap_en = 1'b1;
        tick();
        check("R10 ovf cleared", int'(ovf_flag), 0);
        repeat (3) tick();
        cap_en = 1'b0;
        repeat (5) tick();
        check("R10 short capture", int'(mon_word[mon_n - 1]), 4);
    endtask

    initial begin
        bit hung;
        hung = 1'b0;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                hung = 1'b1;
            end
        join_any
        disable fork;
        if (hung) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule